// File: doc/BRIEF.md
# Unrolled Pipelined SHA-256 Compressor

This block evaluates the SHA-256 compression function on a fresh 512-bit message block and 256-bit chaining value every clock. The 64 rounds are laid out in space, one round stage per round, built by a generate loop. Each stage holds two register levels. Arriving data lands first in a stage buffer. The round result is then computed from that buffer into the stage output register. Each round therefore spends two clocks, and a block needs 128 clocks to cross the pipeline. Once the pipeline is full, one digest leaves per clock.

Every stage carries five things side by side: the eight working variables, a sliding 16-word message-schedule window, the block's own chaining value and a valid bit. At the far end the chaining value is added word by word to the final working variables. This feed-forward produces the digest. Message padding, chaining across blocks and any iteration over input data belong to the surrounding logic.

Top module: `sha256_pipe`

## Requirements
- R1: `out_digest` equals the SHA-256 compression of `in_block` starting from `in_iv`, including the modulo 2^32 feed-forward of `in_iv`. Word 0 of the block is `in_block[511:480]`, and word 15 is `in_block[31:0]`. Working variable a is `in_iv[255:224]`, and h is `in_iv[31:0]`. The digest uses the same order, with H0 in `out_digest[255:224]`.
- R2: A block presented with `in_valid` high before clock edge n appears with `out_valid` high after edge n+127. That is a latency of 128 clocks.
- R3: Blocks presented on consecutive clocks come out on consecutive clocks, in input order. This gives one digest per clock.
- R4: A clock with `in_valid` low produces a clock with `out_valid` low 128 clocks later. Data on `in_block` and `in_iv` during such a clock has no effect on any digest.
- R5: The chaining value travels with its own block, so neighbouring blocks may use different `in_iv` values.
- R6: A synchronous active-high `rst` clears every valid bit. `out_valid` is low on the clock after reset, and blocks in flight when reset is applied never appear at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the valid bits |
| in_valid | input | 1 | Block and chaining value are valid this clock |
| in_block | input | 512 | Padded message block, word 0 in the top bits |
| in_iv | input | 256 | Chaining value, word a in the top bits |
| out_valid | output | 1 | Digest valid this clock |
| out_digest | output | 256 | Compression result with feed-forward |

## Verification
The hardest situation to reach from the ports is a reset that lands while blocks are spread over the middle of the 128-clock pipeline. The bench sends a short burst, waits until the blocks are deep inside the rounds, pulses reset, and then requires silence at the output for the whole window in which those blocks would have surfaced. A second hard case is a long unbroken stream in which every block carries its own random chaining value, interleaved with random gaps. This exposes any mix-up of chaining values between neighbouring blocks or any slip of the valid bits.

// File: rtl/sha256_pipe.sv
module sha256_pipe #(
  parameter int ROUNDS = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [511:0] in_block,
  input  logic [255:0] in_iv,
  output logic         out_valid,
  output logic [255:0] out_digest
);

  function automatic logic [31:0] rotr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [31:0] kconst(input int i);
    case (i)
      0: return 32'h428a2f98;  1: return 32'h71374491;  2: return 32'hb5c0fbcf;  3: return 32'he9b5dba5;
      4: return 32'h3956c25b;  5: return 32'h59f111f1;  6: return 32'h923f82a4;  7: return 32'hab1c5ed5;
      8: return 32'hd807aa98;  9: return 32'h12835b01; 10: return 32'h243185be; 11: return 32'h550c7dc3;
     12: return 32'h72be5d74; 13: return 32'h80deb1fe; 14: return 32'h9bdc06a7; 15: return 32'hc19bf174;
     16: return 32'he49b69c1; 17: return 32'hefbe4786; 18: return 32'h0fc19dc6; 19: return 32'h240ca1cc;
     20: return 32'h2de92c6f; 21: return 32'h4a7484aa; 22: return 32'h5cb0a9dc; 23: return 32'h76f988da;
     24: return 32'h983e5152; 25: return 32'ha831c66d; 26: return 32'hb00327c8; 27: return 32'hbf597fc7;
     28: return 32'hc6e00bf3; 29: return 32'hd5a79147; 30: return 32'h06ca6351; 31: return 32'h14292967;
     32: return 32'h27b70a85; 33: return 32'h2e1b2138; 34: return 32'h4d2c6dfc; 35: return 32'h53380d13;
     36: return 32'h650a7354; 37: return 32'h766a0abb; 38: return 32'h81c2c92e; 39: return 32'h92722c85;
     40: return 32'ha2bfe8a1; 41: return 32'ha81a664b; 42: return 32'hc24b8b70; 43: return 32'hc76c51a3;
     44: return 32'hd192e819; 45: return 32'hd6990624; 46: return 32'hf40e3585; 47: return 32'h106aa070;
     48: return 32'h19a4c116; 49: return 32'h1e376c08; 50: return 32'h2748774c; 51: return 32'h34b0bcb5;
     52: return 32'h391c0cb3; 53: return 32'h4ed8aa4a; 54: return 32'h5b9cca4f; 55: return 32'h682e6ff3;
     56: return 32'h748f82ee; 57: return 32'h78a5636f; 58: return 32'h84c87814; 59: return 32'h8cc70208;
     60: return 32'h90befffa; 61: return 32'ha4506ceb; 62: return 32'hbef9a3f7; default: return 32'hc67178f2;
    endcase
  endfunction

  logic         lk_v  [0:ROUNDS];
  logic [255:0] lk_st [0:ROUNDS];
  logic [511:0] lk_w  [0:ROUNDS];
  logic [255:0] lk_iv [0:ROUNDS];

  assign lk_v[0]  = in_valid;
  assign lk_st[0] = in_iv;
  assign lk_w[0]  = in_block;
  assign lk_iv[0] = in_iv;

  for (genvar i = 0; i < ROUNDS; i++) begin : g_round
    localparam logic [31:0] KI = kconst(i);

    logic         bv, ov;
    logic [255:0] bst, ost, biv, oiv;
    logic [511:0] bw, ow;
    logic [31:0]  a, b, c, d, e, f, g, h, t1, t2, wn;

    assign {a, b, c, d, e, f, g, h} = bst;
    assign t1 = h + (rotr(e, 6) ^ rotr(e, 11) ^ rotr(e, 25)) + ((e & f) ^ (~e & g))
              + KI + bw[511:480];
    assign t2 = (rotr(a, 2) ^ rotr(a, 13) ^ rotr(a, 22)) + ((a & b) ^ (a & c) ^ (b & c));
    assign wn = (rotr(bw[63:32], 17) ^ rotr(bw[63:32], 19) ^ (bw[63:32] >> 10))
              + bw[223:192]
              + (rotr(bw[479:448], 7) ^ rotr(bw[479:448], 18) ^ (bw[479:448] >> 3))
              + bw[511:480];

    always_ff @(posedge clk) begin
      bst <= lk_st[i];
      bw  <= lk_w[i];
      biv <= lk_iv[i];
      ost <= {t1 + t2, a, b, c, d + t1, e, f, g};
      ow  <= {bw[479:0], wn};
      oiv <= biv;
      if (rst) begin
        bv <= 1'b0;
        ov <= 1'b0;
      end else begin
        bv <= lk_v[i];
        ov <= bv;
      end
    end

    assign lk_v[i+1]  = ov;
    assign lk_st[i+1] = ost;
    assign lk_w[i+1]  = ow;
    assign lk_iv[i+1] = oiv;
  end

  assign out_valid = lk_v[ROUNDS];
  for (genvar j = 0; j < 8; j++) begin : g_ff
    assign out_digest[255-32*j -: 32] = lk_st[ROUNDS][255-32*j -: 32] + lk_iv[ROUNDS][255-32*j -: 32];
  end

endmodule

// File: rtl/sha256_pipe_chk.sv
module sha256_pipe_chk #(
  parameter int LAT = 128
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic out_valid
);

  logic [LAT-1:0] hist;
  logic [8:0]     inflight;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist     <= '0;
      inflight <= '0;
    end else begin
      hist     <= {hist[LAT-2:0], in_valid};
      inflight <= inflight + 9'(in_valid) - 9'(out_valid);
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (rst) out_valid == hist[LAT-1]);
  p_reset_clears_r6: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> !out_valid);
  p_inflight_bound_r3: assert property (@(posedge clk) disable iff (rst) inflight <= 9'(LAT));
  p_out_needs_input_r4: assert property (@(posedge clk) disable iff (rst) out_valid |-> inflight != 9'd0);

endmodule

bind sha256_pipe sha256_pipe_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid)
);

// File: tb/sha256_pipe_tb.sv
`timescale 1ns/1ps
module sha256_pipe_tb;
  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [511:0] in_block = '0;
  logic [255:0] in_iv = '0;
  logic out_valid;
  logic [255:0] out_digest;

  sha256_pipe u_dut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_block(in_block),
                     .in_iv(in_iv), .out_valid(out_valid), .out_digest(out_digest));

  always #2.5 clk = ~clk;

  localparam logic [255:0] STD_IV = {32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                                     32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [255:0] exp_d [0:1023];
  int           exp_t [0:1023];
  string        exp_r [0:1023];
  int wr = 0, rd = 0;
  bit mon_on = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [31:0] kt(input int i);
    logic [31:0] t [64] = '{
      32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
      32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
      32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
      32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
      32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
      32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
      32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
      32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};
    return t[i];
  endfunction

  function automatic logic [255:0] ref_hash(input logic [511:0] blk, input logic [255:0] iv);
    logic [31:0] w [64];
    logic [31:0] a, b, c, d, e, f, g, h, t1, t2;
    for (int j = 0; j < 16; j++) w[j] = blk[511-32*j -: 32];
    for (int j = 16; j < 64; j++)
      w[j] = (rr(w[j-2], 17) ^ rr(w[j-2], 19) ^ (w[j-2] >> 10)) + w[j-7]
           + (rr(w[j-15], 7) ^ rr(w[j-15], 18) ^ (w[j-15] >> 3)) + w[j-16];
    {a, b, c, d, e, f, g, h} = iv;
    for (int j = 0; j < 64; j++) begin
      t1 = h + (rr(e, 6) ^ rr(e, 11) ^ rr(e, 25)) + ((e & f) ^ (~e & g)) + kt(j) + w[j];
      t2 = (rr(a, 2) ^ rr(a, 13) ^ rr(a, 22)) + ((a & b) ^ (a & c) ^ (b & c));
      {a, b, c, d, e, f, g, h} = {t1 + t2, a, b, c, d + t1, e, f, g};
    end
    return {a + iv[255:224], b + iv[223:192], c + iv[191:160], d + iv[159:128],
            e + iv[127:96], f + iv[95:64], g + iv[63:32], h + iv[31:0]};
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int j = 0; j < 16; j++) v[32*j +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input bit v, input logic [511:0] blk, input logic [255:0] iv,
                      input logic [255:0] expd, input string req);
    @(negedge clk);
    in_valid = v; in_block = blk; in_iv = iv;
    if (v) begin
      exp_d[wr] = expd; exp_t[wr] = cyc + 128; exp_r[wr] = req; wr++;
    end
  endtask

  always @(negedge clk) if (mon_on) begin
    if (rd < wr && exp_t[rd] == cyc) begin
      check(out_valid === 1'b1, {exp_r[rd], " R2 valid"}, {255'd0, out_valid}, 256'd1);
      check(out_digest === exp_d[rd], exp_r[rd], out_digest, exp_d[rd]);
      rd++;
    end else if (out_valid !== 1'b0) begin
      check(1'b0, "R4/R6 unexpected out_valid", {255'd0, out_valid}, 256'd0);
    end
  end

  initial begin
    #(5.0 * 20000);
    check(1'b0, "watchdog", 256'd0, 256'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [511:0] blk;
    logic [255:0] iv;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R6 reset state", {255'd0, out_valid}, 256'd0);
    @(negedge clk); rst = 1'b0;
    mon_on = 1;

    // R1: published digests of "" and "abc"
    send(1, {32'h80000000, 480'd0}, STD_IV,
         256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855, "R1 empty");
    send(1, {32'h61626380, 448'd0, 32'h00000018}, STD_IV,
         256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad, "R1 abc");
    // R4: idle clock with junk data
    send(0, rnd512(), {8{32'hdeadbeef}}, '0, "R4");
    // R3/R5: back-to-back stream, each block with its own IV
    for (int k = 0; k < 40; k++) begin
      blk = rnd512(); iv = rnd512()[255:0];
      send(1, blk, iv, ref_hash(blk, iv), "R3 R5 stream");
    end
    // R4: random gaps with junk on idle clocks
    for (int k = 0; k < 60; k++) begin
      blk = rnd512(); iv = rnd512()[255:0];
      if ($urandom_range(0, 2) == 0) send(0, blk, iv, '0, "R4");
      else send(1, blk, iv, ref_hash(blk, iv), "R1 R4 gapped");
    end
    // corner values: all-ones block and IV, all-zero block and IV
    send(1, {512{1'b1}}, {256{1'b1}}, ref_hash({512{1'b1}}, {256{1'b1}}), "R1 ones");
    send(1, '0, '0, ref_hash('0, '0), "R1 zeros");
    send(0, '0, '0, '0, "R4");
    wait (rd == wr);
    repeat (5) @(negedge clk);
    check(rd == wr, "R2 all digests drained", 256'(rd), 256'(wr));

    // R6: reset with blocks deep in flight
    for (int k = 0; k < 6; k++) begin
      blk = rnd512();
      send(1, blk, STD_IV, ref_hash(blk, STD_IV), "R6 flushed");
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (50) @(negedge clk);
    rst = 1'b1; rd = wr;
    @(negedge clk);
    check(out_valid === 1'b0, "R6 out_valid after reset", {255'd0, out_valid}, 256'd0);
    rst = 1'b0;
    repeat (140) @(negedge clk);
    check(out_valid === 1'b0, "R6 no flushed output", {255'd0, out_valid}, 256'd0);

    // R1/R2 after reset: pipeline still works
    send(1, {32'h61626380, 448'd0, 32'h00000018}, STD_IV,
         256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad, "R1 R2 post-reset abc");
    send(0, '0, '0, '0, "R4");
    wait (rd == wr);
    repeat (3) @(negedge clk);
    check(rd == wr, "R2 post-reset drained", 256'(rd), 256'(wr));
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule